// File: doc/BRIEF.md
# Banked Register File Address Decoder

This block sits between an instruction datapath and the data memory of a small controller. Each access names a 7-bit offset inside a 128-byte bank. In a direct access the bank comes from two bank-select bits. When the offset is zero, the access is indirect: it goes through an 8-bit pointer extended by one high bank bit. The block turns every access into one of three results: a byte of the on-block general-purpose RAM, a select for the special-register space, or an unimplemented hole.

The low 32 offsets of every bank belong to special registers, and offset zero is the indirection port. Bank 0 holds 96 RAM bytes above the special registers. Bank 1 holds 32 RAM bytes at A0h-BFh, and its top 16 bytes mirror the top 16 bytes of bank 0. Everything else in banks 1, 2 and 3 is a hole. The 128 RAM bytes are stored in a single inferred block memory. Decode results are registered. Read data follows one clock after the strobe and comes from the RAM, from the special-register responder, or is forced to zero.

Top module: `regfile_bank_decoder`

## Requirements
- R1: While reset is held, and on the first cycle after it, ram_we_o, sfr_sel_o, sfr_we_o and rd_valid_o are 0.
- R2: A direct access forms the 9-bit address {bank_i, addr_i}. Bank-0 offsets 20h-7Fh map to RAM index (offset - 20h), which shows on ram_addr_o one cycle after the strobe.
- R3: Bank-1 offsets 20h-3Fh (addresses A0h-BFh) map to RAM index 60h + (offset - 20h), separate from all bank-0 bytes.
- R4: Bank-1 offsets 70h-7Fh (addresses F0h-FFh) reach the same RAM bytes as bank-0 offsets 70h-7Fh. A write through one view reads back through the other.
- R5: Offsets 01h-1Fh in any bank raise sfr_sel_o one cycle later, with sfr_addr_o = {bank[1:0], offset[4:0]}. A write also raises sfr_we_o with sfr_wdata_o = the written byte. A read returns sfr_rdata_i. No RAM write occurs.
- R6: Holes read 00h and ignore writes. The holes are bank-1 offsets 40h-6Fh and banks 2 and 3 at offsets 20h-7Fh. Such a write raises neither ram_we_o nor sfr_sel_o and changes no RAM byte.
- R7: An access with addr_i = 0 uses the 9-bit address {ibank_i, ptr_i} and is decoded by the same map as a direct access.
- R8: An indirect access whose pointer offset bits ptr_i[6:0] are 0 reads 00h and writes nothing: no RAM write, no special-register select.
- R9: rd_valid_o rises exactly one cycle after rd_i, and rd_data_o is valid in that cycle. A RAM write is visible to any later read.
- R10: A cycle with neither rd_i nor wr_i gives ram_we_o, sfr_sel_o, sfr_we_o and rd_valid_o all 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 7 | Offset within bank; 0 selects indirect |
| bank_i | input | 2 | Bank select for direct access |
| ibank_i | input | 1 | High bank bit for indirect access |
| ptr_i | input | 8 | Pointer for indirect access |
| wdata_i | input | 8 | Write data |
| sfr_rdata_i | input | 8 | Special-register read data, responding to sfr_addr_o |
| ram_addr_o | output | 7 | RAM index of the latest RAM access |
| ram_we_o | output | 1 | A RAM write took place |
| sfr_sel_o | output | 1 | Special-register access in progress |
| sfr_we_o | output | 1 | Special-register write |
| sfr_addr_o | output | 7 | {bank, offset[4:0]} of the special register |
| sfr_wdata_o | output | 8 | Write data for the special register |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read data |

## Verification
The bench first fills bank-0 RAM and both bank-1 regions, then reads the bytes back through the other view and through the pointer. A design that aliased the wrong window, or that overlapped bank-1 RAM with bank 0, returns another location's byte. Writes aimed at holes and at the self-referring pointer are followed by reads of the RAM bytes they could have clobbered. A decoder that folded bank 2 onto bank 0, or that let the indirection port write location zero, is exposed there. Special-register accesses in several banks check the bank bits in sfr_addr_o and confirm that no RAM write was strobed.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_SFR  = 2'd1,
    K_RAM  = 2'd2
  } loc_kind_e;

endpackage

// File: rtl/bankdec_addr_form.sv
module bankdec_addr_form #(
  parameter int OFF_W  = 7,
  parameter int BANK_W = 2,
  parameter int IHI_W  = 1,
  localparam int PTR_W  = OFF_W + 1,
  localparam int FULL_W = OFF_W + BANK_W
) (
  input  logic [OFF_W-1:0]  addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [IHI_W-1:0]  ibank_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [FULL_W-1:0] full_o,
  output logic              indirect_o
);

  // offset zero is the indirection port in every bank
  always_comb begin
    indirect_o = (addr_i == '0);
    if (indirect_o) full_o = {ibank_i, ptr_i};
    else            full_o = {bank_i, addr_i};
  end

endmodule

// File: rtl/bankdec_map.sv
module bankdec_map
  import bankdec_pkg::*;
#(
  parameter int OFF_W     = 7,
  parameter int BANK_W    = 2,
  parameter int SFR_COUNT = 32,
  parameter int B1_GP_CNT = 32,
  parameter int WIN_CNT   = 16,
  localparam int FULL_W    = OFF_W + BANK_W,
  localparam int BANK_SZ   = 1 << OFF_W,
  localparam int B0_GP_CNT = BANK_SZ - SFR_COUNT,
  localparam int RAM_DEPTH = B0_GP_CNT + B1_GP_CNT,
  localparam int RAM_AW    = $clog2(RAM_DEPTH),
  localparam int SFR_OW    = $clog2(SFR_COUNT),
  localparam int SFR_AW    = BANK_W + SFR_OW
) (
  input  logic [FULL_W-1:0] full_i,
  output loc_kind_e         kind_o,
  output logic [RAM_AW-1:0] idx_o,
  output logic [SFR_AW-1:0] sfr_addr_o
);

  logic [BANK_W-1:0] bank;
  logic [OFF_W-1:0]  off;
  logic [OFF_W-1:0]  gp_off;
  logic              in_win;

  assign bank   = full_i[FULL_W-1:OFF_W];
  assign off    = full_i[OFF_W-1:0];
  assign gp_off = off - OFF_W'(SFR_COUNT);

  generate
    if (WIN_CNT > 0) begin : g_win
      assign in_win = (off >= OFF_W'(BANK_SZ - WIN_CNT));
    end else begin : g_nowin
      assign in_win = 1'b0;
    end
  endgenerate

  always_comb begin
    kind_o     = K_NONE;
    idx_o      = '0;
    sfr_addr_o = {bank, off[SFR_OW-1:0]};
    if (off == '0) begin
      kind_o = K_NONE;                       // self-reference of the port
    end else if (off < OFF_W'(SFR_COUNT)) begin
      kind_o = K_SFR;
    end else if (bank == BANK_W'(0)) begin
      kind_o = K_RAM;
      idx_o  = RAM_AW'(gp_off);
    end else if (bank == BANK_W'(1)) begin
      if (off < OFF_W'(SFR_COUNT + B1_GP_CNT)) begin
        kind_o = K_RAM;
        idx_o  = RAM_AW'(B0_GP_CNT) + RAM_AW'(gp_off);
      end else if (in_win) begin
        kind_o = K_RAM;
        idx_o  = RAM_AW'(gp_off);           // mirror of bank-0 top
      end
    end
  end

endmodule

// File: rtl/bankdec_ram.sv
module bankdec_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single port, block RAM shape
  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rdata_o <= mem[addr_i];
  end

endmodule

// File: rtl/regfile_bank_decoder.sv
module regfile_bank_decoder
  import bankdec_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 7,
  parameter int BANK_W    = 2,
  parameter int IHI_W     = 1,
  parameter int SFR_COUNT = 32,
  parameter int B1_GP_CNT = 32,
  parameter int WIN_CNT   = 16,
  localparam int PTR_W     = OFF_W + 1,
  localparam int FULL_W    = OFF_W + BANK_W,
  localparam int RAM_DEPTH = (1 << OFF_W) - SFR_COUNT + B1_GP_CNT,
  localparam int RAM_AW    = $clog2(RAM_DEPTH),
  localparam int SFR_AW    = BANK_W + $clog2(SFR_COUNT)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [IHI_W-1:0]  ibank_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] sfr_rdata_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              sfr_sel_o,
  output logic              sfr_we_o,
  output logic [SFR_AW-1:0] sfr_addr_o,
  output logic [DATA_W-1:0] sfr_wdata_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [FULL_W-1:0] full;
  logic              indirect;
  loc_kind_e         kind;
  loc_kind_e         kind_q;
  logic [RAM_AW-1:0] idx;
  logic [SFR_AW-1:0] sfr_a;
  logic [DATA_W-1:0] ram_q;
  logic              req;
  logic              mem_we;

  assign req = rd_i | wr_i;

  bankdec_addr_form #(
    .OFF_W (OFF_W), .BANK_W(BANK_W), .IHI_W(IHI_W)
  ) u_form (
    .addr_i    (addr_i),
    .bank_i    (bank_i),
    .ibank_i   (ibank_i),
    .ptr_i     (ptr_i),
    .full_o    (full),
    .indirect_o(indirect)
  );

  bankdec_map #(
    .OFF_W(OFF_W), .BANK_W(BANK_W), .SFR_COUNT(SFR_COUNT),
    .B1_GP_CNT(B1_GP_CNT), .WIN_CNT(WIN_CNT)
  ) u_map (
    .full_i    (full),
    .kind_o    (kind),
    .idx_o     (idx),
    .sfr_addr_o(sfr_a)
  );

  assign mem_we = wr_i && (kind == K_RAM) && !rst_i;

  bankdec_ram #(
    .DATA_W(DATA_W), .DEPTH(RAM_DEPTH)
  ) u_ram (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .addr_i (idx),
    .wdata_i(wdata_i),
    .rdata_o(ram_q)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ram_we_o    <= 1'b0;
      sfr_sel_o   <= 1'b0;
      sfr_we_o    <= 1'b0;
      rd_valid_o  <= 1'b0;
      kind_q      <= K_NONE;
      ram_addr_o  <= '0;
      sfr_addr_o  <= '0;
      sfr_wdata_o <= '0;
    end else begin
      ram_we_o   <= wr_i && (kind == K_RAM);
      sfr_sel_o  <= req && (kind == K_SFR);
      sfr_we_o   <= wr_i && (kind == K_SFR);
      rd_valid_o <= rd_i;
      kind_q     <= req ? kind : K_NONE;
      if (req && kind == K_RAM) ram_addr_o <= idx;
      if (req && kind == K_SFR) sfr_addr_o <= sfr_a;
      if (wr_i) sfr_wdata_o <= wdata_i;
    end
  end

  always_comb begin
    case (kind_q)
      K_RAM:   rd_data_o = ram_q;
      K_SFR:   rd_data_o = sfr_rdata_i;
      default: rd_data_o = '0;
    endcase
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    rst_i |=> (!ram_we_o && !sfr_sel_o && !sfr_we_o && !rd_valid_o));

  // R10
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    !(rd_i || wr_i) |=> (!ram_we_o && !sfr_sel_o && !sfr_we_o && !rd_valid_o));

  // R9
  a_r9_rd_latency: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_i |=> rd_valid_o);

  // R8
  a_r8_self_ref: assert property (@(posedge clk_i) disable iff (rst_i)
    ((rd_i || wr_i) && addr_i == '0 && ptr_i[OFF_W-1:0] == '0)
      |=> (!ram_we_o && !sfr_sel_o && !sfr_we_o));

  // R5
  a_r5_sfr_no_ram: assert property (@(posedge clk_i) disable iff (rst_i)
    sfr_sel_o |-> !ram_we_o);

  // R6
  a_r6_hole_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_valid_o && !sfr_sel_o && kind_q != K_RAM) |-> (rd_data_o == '0));

endmodule

// File: tb/regfile_bank_decoder_tb_top.sv
module regfile_bank_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       rd, wr;
  logic [6:0] addr;
  logic [1:0] bank;
  logic       ibank;
  logic [7:0] ptr;
  logic [7:0] wdata;
  logic [7:0] sfr_rdata;
  logic [6:0] ram_addr;
  logic       ram_we, sfr_sel, sfr_we, rd_valid;
  logic [6:0] sfr_addr;
  logic [7:0] sfr_wdata;
  logic [7:0] rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench-side special-register responder
  assign sfr_rdata = {1'b0, sfr_addr} ^ 8'hC3;

  regfile_bank_decoder dut_i (
    .clk_i(clk), .rst_i(rst), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .bank_i(bank), .ibank_i(ibank), .ptr_i(ptr),
    .wdata_i(wdata), .sfr_rdata_i(sfr_rdata),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .sfr_sel_o(sfr_sel),
    .sfr_we_o(sfr_we), .sfr_addr_o(sfr_addr), .sfr_wdata_o(sfr_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  typedef struct {
    string      tag;
    bit         rd;
    bit         wr;
    int         kind;   // 0 none, 1 sfr, 2 ram
    logic [6:0] ridx;
    logic [6:0] saddr;
    logic [7:0] wdat;
    logic [7:0] rdat;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] model [128];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // independent address map taken from the requirements
  task automatic bmap(input logic [8:0] a, output int kind, output logic [6:0] idx);
    logic [6:0] off;
    logic [1:0] bk;
    off  = a[6:0];
    bk   = a[8:7];
    kind = 0;
    idx  = '0;
    if (off == 7'h00)                     kind = 0;
    else if (off < 7'h20)                 kind = 1;
    else if (bk == 2'd0)                  begin kind = 2; idx = off - 7'h20; end
    else if (bk == 2'd1 && off < 7'h40)   begin kind = 2; idx = 7'h60 + (off - 7'h20); end
    else if (bk == 2'd1 && off >= 7'h70)  begin kind = 2; idx = off - 7'h20; end
  endtask

  task automatic op(string tag, bit r, bit w, logic [1:0] bk, logic [6:0] a,
                    logic ib, logic [7:0] p, logic [7:0] d);
    exp_t       e;
    logic [8:0] full;
    @(negedge clk);
    rd = r; wr = w; bank = bk; addr = a; ibank = ib; ptr = p; wdata = d;
    full = (a == 7'h00) ? {ib, p} : {bk, a};
    e.tag = tag; e.rd = r; e.wr = w; e.wdat = d;
    bmap(full, e.kind, e.ridx);
    if (!(r || w)) e.kind = 0;
    e.saddr = {full[8:7], full[4:0]};
    if (e.kind == 2)      e.rdat = model[e.ridx];
    else if (e.kind == 1) e.rdat = {1'b0, e.saddr} ^ 8'hC3;
    else                  e.rdat = 8'h00;
    if (w && e.kind == 2) model[e.ridx] = d;
    sb.push_back(e);
  endtask

  task automatic idle();
    op("R10", 0, 0, 2'd0, 7'h20, 1'b0, 8'h00, 8'h00);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " ram_we"},   ram_we,   (e.wr && e.kind == 2));
        chk({e.tag, " sfr_sel"},  sfr_sel,  (e.kind == 1));
        chk({e.tag, " sfr_we"},   sfr_we,   (e.wr && e.kind == 1));
        chk({e.tag, " rd_valid"}, rd_valid, e.rd);
        if (e.kind == 2) chk({e.tag, " ram_addr"}, ram_addr, e.ridx);
        if (e.kind == 1) chk({e.tag, " sfr_addr"}, sfr_addr, e.saddr);
        if (e.kind == 1 && e.wr) chk({e.tag, " sfr_wdata"}, sfr_wdata, e.wdat);
        if (e.rd) chk({e.tag, " rd_data"}, rd_data, e.rdat);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rd = 0; wr = 0; addr = '0; bank = '0; ibank = 0; ptr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 ram_we", ram_we, 0);
    chk("R1 sfr_sel", sfr_sel, 0);
    chk("R1 rd_valid", rd_valid, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after release rd_valid", rd_valid, 0);
    chk("R1 after release ram_we", ram_we, 0);

    idle();
    // R2: fill bank 0 RAM, then read the edges
    for (int i = 8'h20; i < 8'h80; i++)
      op("R2", 0, 1, 2'd0, 7'(i), 1'b0, 8'h00, 8'(i * 3 + 1));
    op("R2", 1, 0, 2'd0, 7'h20, 1'b0, 8'h00, 8'h00);
    op("R2", 1, 0, 2'd0, 7'h7F, 1'b0, 8'h00, 8'h00);
    // R3: bank 1 region, distinct from bank 0
    op("R3", 0, 1, 2'd1, 7'h20, 1'b0, 8'h00, 8'hA0);
    op("R3", 0, 1, 2'd1, 7'h3F, 1'b0, 8'h00, 8'hBF);
    op("R3", 1, 0, 2'd1, 7'h20, 1'b0, 8'h00, 8'h00);
    op("R3", 1, 0, 2'd1, 7'h3F, 1'b0, 8'h00, 8'h00);
    op("R3", 1, 0, 2'd0, 7'h20, 1'b0, 8'h00, 8'h00);
    op("R3", 1, 0, 2'd0, 7'h3F, 1'b0, 8'h00, 8'h00);
    // R4: mirrored window both directions
    op("R4", 0, 1, 2'd1, 7'h75, 1'b0, 8'h00, 8'h5E);
    op("R4", 1, 0, 2'd0, 7'h75, 1'b0, 8'h00, 8'h00);
    op("R4", 0, 1, 2'd0, 7'h70, 1'b0, 8'h00, 8'h77);
    op("R4", 1, 0, 2'd1, 7'h70, 1'b0, 8'h00, 8'h00);
    op("R4", 1, 0, 2'd1, 7'h7F, 1'b0, 8'h00, 8'h00);
    // R5: special registers in several banks
    op("R5", 1, 0, 2'd0, 7'h03, 1'b0, 8'h00, 8'h00);
    op("R5", 0, 1, 2'd1, 7'h0B, 1'b0, 8'h00, 8'h9D);
    op("R5", 1, 0, 2'd3, 7'h1F, 1'b0, 8'h00, 8'h00);
    op("R5", 0, 1, 2'd2, 7'h01, 1'b0, 8'h00, 8'h42);
    // R6: holes read zero and writes have no effect
    op("R6", 0, 1, 2'd1, 7'h45, 1'b0, 8'h00, 8'hEE);
    op("R6", 1, 0, 2'd1, 7'h45, 1'b0, 8'h00, 8'h00);
    op("R6", 0, 1, 2'd2, 7'h20, 1'b0, 8'h00, 8'hEE);
    op("R6", 0, 1, 2'd3, 7'h7F, 1'b0, 8'h00, 8'hEE);
    op("R6", 1, 0, 2'd0, 7'h20, 1'b0, 8'h00, 8'h00);
    op("R6", 1, 0, 2'd0, 7'h7F, 1'b0, 8'h00, 8'h00);
    op("R6", 1, 0, 2'd1, 7'h20, 1'b0, 8'h00, 8'h00);
    op("R6", 1, 0, 2'd2, 7'h50, 1'b0, 8'h00, 8'h00);
    // R7: indirect accesses
    op("R7", 0, 1, 2'd3, 7'h00, 1'b0, 8'hA5, 8'h3C);
    op("R7", 1, 0, 2'd1, 7'h25, 1'b0, 8'h00, 8'h00);
    op("R7", 1, 0, 2'd0, 7'h00, 1'b0, 8'h83, 8'h00);
    op("R7", 1, 0, 2'd0, 7'h00, 1'b1, 8'h20, 8'h00);
    op("R7", 1, 0, 2'd2, 7'h00, 1'b0, 8'hF6, 8'h00);
    for (int i = 8'h20; i < 8'h80; i += 8'h0D)
      op("R7", 1, 0, 2'd1, 7'h00, 1'b0, 8'(i), 8'h00);
    // R8: pointer names the indirection port itself
    op("R8", 0, 1, 2'd0, 7'h00, 1'b0, 8'h00, 8'hFF);
    op("R8", 0, 1, 2'd1, 7'h00, 1'b1, 8'h80, 8'hFF);
    op("R8", 1, 0, 2'd0, 7'h00, 1'b0, 8'h80, 8'h00);
    op("R8", 1, 0, 2'd0, 7'h00, 1'b1, 8'h00, 8'h00);
    op("R8", 1, 0, 2'd0, 7'h20, 1'b0, 8'h00, 8'h00);
    // R9: back-to-back write then read of the same byte
    op("R9", 0, 1, 2'd0, 7'h44, 1'b0, 8'h00, 8'hC1);
    op("R9", 1, 0, 2'd0, 7'h44, 1'b0, 8'h00, 8'h00);
    idle();
    op("R9", 1, 0, 2'd0, 7'h45, 1'b0, 8'h00, 8'h00);
    idle();
    idle();
    @(posedge clk); #2;
    chk("R10 drained", sb.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule